// File: doc/BRIEF.md
# Latched Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream in two stages. A holding register grabs the parallel input word whenever its capture strobe rises. A separate shift chain of the same width can then be filled from the holding register, cleared, or advanced by one position on each rising edge of a shift strobe. The serial output is the top stage of the chain. Because the holding register has its own strobe, a new word can be staged while the previous one is still moving out.

Both strobes are treated as ordinary data signals sampled by one system clock. A rising edge on either strobe is detected inside the block and acts as a one-cycle enable. The load and clear controls are active-low levels that are sampled on every system cycle, and they take precedence over shifting. When both are asserted together the chain is cleared, and a sticky error flag stays set until the synchronous reset. The interface has no handshake. Data moves on strobe edges and control levels only, and the serial output cannot apply back-pressure, so a consumer must follow the shift strobe it drives.

Top module: `piso_latch_shifter`

## Requirements
- R1: While `srst` is high at a rising `clk` edge, the holding register, the shift chain and `ctl_err` all become zero. A load issued right after reset therefore yields an all-zero chain.
- R2: In any cycle where `cap_clk` is sampled high after being sampled low, the holding register takes `par_in`, whatever the levels of `load_n`, `clear_n` and `shf_clk`.
- R3: With `load_n` low and `clear_n` high, the chain takes the holding register contents one cycle later. This happens whether or not the shift strobe rises.
- R4: With `clear_n` low and `load_n` high, the chain becomes all zeros one cycle later, even if the shift strobe rises.
- R5: With both controls high, a rising edge of `shf_clk` moves the chain by one. Stage 0 takes `ser_in`, and stage n takes the old stage n-1.
- R6: With both controls high, the chain holds its value in any cycle without a rising edge of `shf_clk`, including cycles where `cap_clk` rises.
- R7: If `load_n` and `clear_n` are low together, the chain is cleared and `ctl_err` rises one cycle later. `ctl_err` then stays high until `srst`.
- R8: `ser_out` equals stage W-1 of the chain, which is bit 7 of `shf_q` at the default width. After a load, the word leaves most significant bit first: bit W-1 appears at once, and bit 0 appears after W-1 shift edges.
- R9: If a capture edge and an active load fall in the same cycle, the chain takes the holding value from before that capture. The new word reaches the chain only on a later load cycle.
- R10: A shift strobe held high over several cycles advances the chain only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| cap_clk | input | 1 | Capture strobe; its rising edge stages `par_in` |
| par_in | input | W | Parallel word to stage |
| shf_clk | input | 1 | Shift strobe; its rising edge advances the chain |
| load_n | input | 1 | Active-low level: copy holding register into chain |
| clear_n | input | 1 | Active-low level: zero the chain |
| ser_in | input | 1 | Serial data entering stage 0 |
| ser_out | output | 1 | Serial data from stage W-1 |
| shf_q | output | W | Full shift-chain contents, for test |
| ctl_err | output | 1 | Sticky flag: load and clear were asserted together |

## Verification
The bench aims at the cycles where two actions meet. A capture and a load in the same cycle must transfer the old word; a design that forwards `par_in` instead would show the new word one load too early. Load and clear both win over a shift edge that arrives at the same time; a design with the wrong precedence would shift the loaded word or leave residue where zeros belong. A shift strobe held high is checked to advance the chain only once; a level-triggered design would race through the word. The bench also asserts load and clear together, then checks that the chain is zero and that the error flag survives later normal operation. A design that let go of the flag, or loaded instead of cleared, would be reported.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;

  // Per-cycle action selected for the shift chain
  typedef enum logic [2:0] {
    SH_HOLD  = 3'd0,
    SH_STEP  = 3'd1,
    SH_LOAD  = 3'd2,
    SH_ZERO  = 3'd3,
    SH_CLASH = 3'd4   // load and clear together: zero and flag
  } sh_mode_e;

endpackage

// File: rtl/piso_edge_det.sv
`timescale 1ns/1ps
// Rising-edge detector for N level signals sampled in the system clock.
// The previous-level registers reset high, so a level already high at
// reset release is not taken as an edge.
module piso_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (srst) prev_q[i] <= 1'b1;
      else      prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end

endmodule

// File: rtl/piso_word_latch.sv
`timescale 1ns/1ps
// Holding register: stages the parallel word on a capture enable.
module piso_word_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         cap_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (srst)        word_q <= '0;
    else if (cap_en) word_q <= din;
  end

endmodule

// File: rtl/piso_ctl_decode.sv
`timescale 1ns/1ps
// Resolves the two active-low levels and the shift enable into one mode.
// Clear wins over load; clear plus load is a clash that sets a sticky flag.
module piso_ctl_decode
  import piso_pkg::*;
(
  input  logic     clk,
  input  logic     srst,
  input  logic     load_n,
  input  logic     clear_n,
  input  logic     step_en,
  output sh_mode_e mode,
  output logic     clash_q
);

  always_comb begin
    unique casez ({clear_n, load_n, step_en})
      3'b00?:  mode = SH_CLASH;
      3'b01?:  mode = SH_ZERO;
      3'b10?:  mode = SH_LOAD;
      3'b111:  mode = SH_STEP;
      default: mode = SH_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst)                  clash_q <= 1'b0;
    else if (mode == SH_CLASH) clash_q <= 1'b1;
  end

endmodule

// File: rtl/piso_shift_chain.sv
`timescale 1ns/1ps
// W-stage shift chain: stage 0 takes the serial input, stage i the old
// stage i-1. Load and zero act on all stages in the same cycle.
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst,
  input  sh_mode_e     mode,
  input  logic         sin,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] q
);

  logic [W-1:0] stepped;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stepped[i] = sin;
    end else begin : g_body
      assign stepped[i] = q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      q <= '0;
    end else begin
      unique case (mode)
        SH_CLASH, SH_ZERO: q <= '0;
        SH_LOAD:           q <= load_word;
        SH_STEP:           q <= stepped;
        default:           q <= q;
      endcase
    end
  end

endmodule

// File: rtl/piso_latch_shifter.sv
`timescale 1ns/1ps
// Top: holding register feeding a loadable, clearable shift chain,
// both driven by strobe edges detected in the system clock.
module piso_latch_shifter
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         cap_clk,
  input  logic [W-1:0] par_in,
  input  logic         shf_clk,
  input  logic         load_n,
  input  logic         clear_n,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] shf_q,
  output logic         ctl_err
);

  localparam int NSTROBE = 2;
  localparam int CAP_IX  = 0;
  localparam int SHF_IX  = 1;

  logic [NSTROBE-1:0] strobe_lvl;
  logic [NSTROBE-1:0] strobe_rise;
  logic               cap_rise;
  logic               shf_rise;
  logic [W-1:0]       store_q;
  sh_mode_e           mode;

  assign strobe_lvl[CAP_IX] = cap_clk;
  assign strobe_lvl[SHF_IX] = shf_clk;
  assign cap_rise = strobe_rise[CAP_IX];
  assign shf_rise = strobe_rise[SHF_IX];

  piso_edge_det #(.N(NSTROBE)) u_edges (
    .clk  (clk),
    .srst (srst),
    .lvl  (strobe_lvl),
    .rise (strobe_rise)
  );

  piso_word_latch #(.W(W)) u_hold (
    .clk    (clk),
    .srst   (srst),
    .cap_en (cap_rise),
    .din    (par_in),
    .word_q (store_q)
  );

  piso_ctl_decode u_ctl (
    .clk     (clk),
    .srst    (srst),
    .load_n  (load_n),
    .clear_n (clear_n),
    .step_en (shf_rise),
    .mode    (mode),
    .clash_q (ctl_err)
  );

  // store_q is the pre-capture value in a capture+load cycle
  piso_shift_chain #(.W(W)) u_chain (
    .clk       (clk),
    .srst      (srst),
    .mode      (mode),
    .sin       (ser_in),
    .load_word (store_q),
    .q         (shf_q)
  );

  assign ser_out = shf_q[W-1];

endmodule

// File: rtl/piso_latch_shifter_chk.sv
`timescale 1ns/1ps
module piso_latch_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         srst,
  input logic         cap_rise,
  input logic         shf_rise,
  input logic [W-1:0] par_in,
  input logic         ser_in,
  input logic         load_n,
  input logic         clear_n,
  input logic [W-1:0] store_q,
  input logic [W-1:0] shf_q,
  input logic         ctl_err
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    srst |=> (shf_q == '0 && store_q == '0 && !ctl_err));

  assert_capture_R2: assert property (@(posedge clk) disable iff (srst)
    cap_rise |=> store_q == $past(par_in));

  assert_load_R3: assert property (@(posedge clk) disable iff (srst)
    (!load_n && clear_n) |=> shf_q == $past(store_q));

  assert_clear_R4: assert property (@(posedge clk) disable iff (srst)
    (load_n && !clear_n) |=> shf_q == '0);

  assert_step_R5: assert property (@(posedge clk) disable iff (srst)
    (load_n && clear_n && shf_rise) |=> shf_q == {$past(shf_q[W-2:0]), $past(ser_in)});

  assert_hold_R6: assert property (@(posedge clk) disable iff (srst)
    (load_n && clear_n && !shf_rise) |=> $stable(shf_q));

  assert_clash_R7: assert property (@(posedge clk) disable iff (srst)
    (!load_n && !clear_n) |=> (shf_q == '0 && ctl_err));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (srst)
    ctl_err |=> ctl_err);

endmodule

bind piso_latch_shifter piso_latch_shifter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .srst     (srst),
  .cap_rise (cap_rise),
  .shf_rise (shf_rise),
  .par_in   (par_in),
  .ser_in   (ser_in),
  .load_n   (load_n),
  .clear_n  (clear_n),
  .store_q  (store_q),
  .shf_q    (shf_q),
  .ctl_err  (ctl_err)
);

// File: tb/tb_piso_latch_shifter.sv
`timescale 1ns/1ps
module tb_piso_latch_shifter;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         srst = 1'b1;
  logic         cap_clk = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         shf_clk = 1'b0;
  logic         load_n = 1'b1;
  logic         clear_n = 1'b1;
  logic         ser_in = 1'b0;
  logic         ser_out;
  logic [W-1:0] shf_q;
  logic         ctl_err;

  always #5 clk = ~clk;

  piso_latch_shifter #(.W(W)) dut (
    .clk(clk), .srst(srst), .cap_clk(cap_clk), .par_in(par_in),
    .shf_clk(shf_clk), .load_n(load_n), .clear_n(clear_n),
    .ser_in(ser_in), .ser_out(ser_out), .shf_q(shf_q), .ctl_err(ctl_err)
  );

  typedef struct {
    logic [W-1:0] q;
    logic         err;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Reference model built from the requirements
  logic [W-1:0] m_store, m_q;
  logic         m_err, m_pc, m_ps;

  task automatic push(string tag);
    exp_t e;
    e.q = m_q; e.err = m_err; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    srst = 1'b1; cap_clk = 1'b0; shf_clk = 1'b0; load_n = 1'b1; clear_n = 1'b1;
    @(posedge clk); #1;
    m_store = '0; m_q = '0; m_err = 1'b0; m_pc = 1'b1; m_ps = 1'b1;
    push(tag);
    @(negedge clk);
    srst = 1'b0;
  endtask

  task automatic step(input logic cap, input logic [W-1:0] par, input logic shf,
                      input logic ldn, input logic clrn, input logic sin, input string tag);
    logic cr, sr;
    logic [W-1:0] old;
    @(negedge clk);
    cap_clk = cap; par_in = par; shf_clk = shf; load_n = ldn; clear_n = clrn; ser_in = sin;
    @(posedge clk); #1;
    cr = cap & ~m_pc; sr = shf & ~m_ps; m_pc = cap; m_ps = shf;
    old = m_store;
    if (cr) m_store = par;                         // R2
    if (!clrn) begin
      m_q = '0;                                    // R4
      if (!ldn) m_err = 1'b1;                      // R7
    end else if (!ldn) m_q = old;                  // R3, R9
    else if (sr) m_q = {m_q[W-2:0], sin};          // R5, R10
    push(tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, tag);
  endtask

  // Monitor: compare one scoreboard entry per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      n_chk++;
      if (shf_q !== cur.q || ser_out !== cur.q[W-1] || ctl_err !== cur.err) begin
        n_fail++;
        $display("FAIL %s: shf_q=%h ser_out=%b ctl_err=%b expected shf_q=%h ser_out=%b ctl_err=%b",
                 cur.tag, shf_q, ser_out, ctl_err, cur.q, cur.q[W-1], cur.err);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset("R1 reset state");
    idle("R1 idle after reset");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 load of reset storage");
    idle("R6 idle");
    // capture with load inactive: chain untouched
    step(1'b1, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, "R6 capture leaves chain");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R3 load A5 R8 msb out");
    idle("R6 hold");
    // shift out seven bits
    for (int i = 0; i < W-1; i++) begin
      step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0, "R5 shift R8 serial order");
      step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 shift strobe low");
    end
    // serial input shifting ones
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R5 shift in one");
    idle("R6 hold");
    // held-high shift strobe
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R10 first edge");
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R10 held high no shift");
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 still held");
    idle("R6 hold");
    // capture during clear, then load shows it
    step(1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, "R2 capture during clear R4");
    step(1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b1, "R3 load overrides shift edge");
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 hold");
    // capture and load in same cycle
    step(1'b1, 8'h96, 1'b0, 1'b0, 1'b1, 1'b0, "R9 old word on simultaneous capture");
    step(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, "R9 new word on later load");
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R5 shift after load");
    // clear overrides shift edge
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 hold");
    step(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 clear overrides shift");
    step(1'b1, 8'hF0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 load after clear");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 load F0");
    // invalid combination
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 clash clears and flags");
    idle("R7 flag sticky");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R7 flag survives load");
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R7 flag survives shift");
    do_reset("R1 reset clears flag");
    idle("R1 idle after second reset");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule